// File: doc/BRIEF.md
# Time-Triggered State Message Buffer

This block is a slot store that decouples a time-triggered communication controller from a host. The controller side offers a data word and the sampling time of the observation. The buffer takes that pair into a slot only at instants fixed in advance. Each slot has a phase within a repeating global-time round and an enable bit. When the low bits of the global time equal the phase of an enabled slot, that slot is overwritten in place. No queue exists, so a newer observation simply replaces the older one.

The host picks a slot at any time and gets its contents back one clock later. The read is non-consuming: it never alters the slot, so the same entry can be read as often as wanted. Along with the value and its timestamp, the host gets a freshness bit. The bit is set only when the slot has been written since reset and the observation age is no larger than that slot's programmed accuracy limit. The age is the current global time minus the stored timestamp, taken modulo the time width. No ready, acknowledge or interrupt line crosses the buffer. The receiver alone judges whether the data is usable.

Top module: `ttsm_buffer`

## Requirements
- R1: After reset, and for any slot never written since reset, a read returns data 0, timestamp 0 and a freshness bit of 0.
- R2: When an enabled slot's phase field (bits PHASE_W*i upward of `cfg_phase`) equals `gtime[PHASE_W-1:0]` at a clock edge, that slot takes `cw_data` and `cw_stamp` at that edge, replacing its previous contents.
- R3: At edges where no enabled slot's phase matches the global time, `cw_data` and `cw_stamp` have no effect on any slot.
- R4: Reading a slot leaves it unchanged; repeated reads with no write in between return the same data and timestamp.
- R5: Read outputs are registered: they reflect the `rd_slot` presented at the most recent clock edge and do not change between edges.
- R6: A read at the same edge as a write to the selected slot returns the complete previous entry (data and timestamp); the new entry appears on the following read.
- R7: `rd_valid` is 1 exactly when the slot has been written and (gtime at the read edge − stored timestamp) mod 2^32 ≤ that slot's limit in `cfg_acc` (bits 32*i upward).
- R8: An age equal to the limit counts as fresh and one tick more as stale; a timestamp ahead of the global time yields a huge modular age and reads stale; an age across the 32-bit wrap is computed modulo 2^32.
- R9: When several enabled slots share the matching phase, only the lowest-numbered one is written.
- R10: A slot whose bit in `cfg_slot_en` is 0 is never written, whatever its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gtime | input | 32 | Global time in ticks |
| cfg_slot_en | input | NSLOT | Per-slot schedule enable |
| cfg_phase | input | NSLOT*PHASE_W | Per-slot write phase within the global-time round |
| cfg_acc | input | NSLOT*32 | Per-slot accuracy limit in ticks |
| cw_data | input | DATA_W | Observation value offered by the controller |
| cw_stamp | input | 32 | Sampling time of the offered observation |
| rd_slot | input | $clog2(NSLOT) | Slot the host reads |
| rd_data | output | DATA_W | Stored value of the read slot |
| rd_stamp | output | 32 | Stored timestamp of the read slot |
| rd_valid | output | 1 | Freshness of the read entry |

## Verification
The bench targets a read that coincides with a write to the same slot. A design that forwards the incoming word, or mixes the fields, would return the new value or a torn entry at that edge. It probes the freshness limit one tick on each side, a stamp ahead of the clock, and an age that crosses the 32-bit wrap. A signed or non-modular subtraction, or a strict less-than, would flip the valid bit in one of these cases. It also offers changing controller data at unscheduled instants, on a disabled slot and on two slots sharing one phase. A buffer that writes without a schedule match, ignores the enable, or lets the higher slot win would then hold the wrong value.

// File: rtl/ttsm_pkg.sv
package ttsm_pkg;
  localparam int TS_W = 32;
  typedef logic [TS_W-1:0] gtime_t;

  // Modular age compared against the allowed accuracy interval.
  function automatic logic age_within(gtime_t now, gtime_t stamp, gtime_t limit);
    gtime_t age;
    age = now - stamp;
    return (age <= limit);
  endfunction
endpackage

// File: rtl/ttsm_sched.sv
module ttsm_sched #(
  parameter  int NSLOT   = 8,
  parameter  int PHASE_W = 4,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic [PHASE_W-1:0]       now_phase,
  input  logic [NSLOT-1:0]         slot_en,
  input  logic [NSLOT*PHASE_W-1:0] slot_phase,
  output logic                     hit,
  output logic [SLOT_W-1:0]        slot
);
  logic [NSLOT-1:0] match;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_match
      assign match[i] = slot_en[i] &&
                        (slot_phase[i*PHASE_W +: PHASE_W] == now_phase);
    end
  endgenerate

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit  = 1'b0;
    slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        slot = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/ttsm_store.sv
module ttsm_store
  import ttsm_pkg::*;
#(
  parameter  int NSLOT  = 8,
  parameter  int DATA_W = 32,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  gtime_t            wr_stamp,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output gtime_t            rd_stamp,
  output logic              rd_written
);
  logic [DATA_W-1:0] data_view  [NSLOT];
  gtime_t            stamp_view [NSLOT];
  logic [NSLOT-1:0]  written_view;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic              load;
      logic [DATA_W-1:0] data_q;
      gtime_t            stamp_q;
      logic              written_q;

      always_comb begin
        load = wr_en && (wr_slot == SLOT_W'(i));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q    <= '0;
          stamp_q   <= '0;
          written_q <= 1'b0;
        end else if (load) begin
          data_q    <= wr_data;
          stamp_q   <= wr_stamp;
          written_q <= 1'b1;
        end
      end

      assign data_view[i]    = data_q;
      assign stamp_view[i]   = stamp_q;
      assign written_view[i] = written_q;
    end
  endgenerate

  always_comb begin
    rd_data    = data_view[rd_slot];
    rd_stamp   = stamp_view[rd_slot];
    rd_written = written_view[rd_slot];
  end
endmodule

// File: rtl/ttsm_fresh.sv
module ttsm_fresh
  import ttsm_pkg::*;
#(
  parameter  int NSLOT  = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  gtime_t               now,
  input  logic [SLOT_W-1:0]    sel_slot,
  input  logic [NSLOT*TS_W-1:0] limits,
  input  gtime_t               stamp,
  input  logic                 written,
  output logic                 fresh
);
  gtime_t limit_sel;

  always_comb begin
    limit_sel = limits[sel_slot*TS_W +: TS_W];
    fresh     = written && age_within(now, stamp, limit_sel);
  end
endmodule

// File: rtl/ttsm_buffer.sv
module ttsm_buffer
  import ttsm_pkg::*;
#(
  parameter  int NSLOT   = 8,
  parameter  int DATA_W  = 32,
  parameter  int PHASE_W = 4,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          gtime,
  input  logic [NSLOT-1:0]         cfg_slot_en,
  input  logic [NSLOT*PHASE_W-1:0] cfg_phase,
  input  logic [NSLOT*TS_W-1:0]    cfg_acc,
  input  logic [DATA_W-1:0]        cw_data,
  input  logic [TS_W-1:0]          cw_stamp,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [DATA_W-1:0]        rd_data,
  output logic [TS_W-1:0]          rd_stamp,
  output logic                     rd_valid
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              wr_hit;
  logic [SLOT_W-1:0] wr_slot;

  ttsm_sched #(.NSLOT(NSLOT), .PHASE_W(PHASE_W)) u_sched (
    .now_phase  (gtime[PHASE_W-1:0]),
    .slot_en    (cfg_slot_en),
    .slot_phase (cfg_phase),
    .hit        (wr_hit),
    .slot       (wr_slot)
  );

  logic [DATA_W-1:0] st_data;
  gtime_t            st_stamp;
  logic              st_written;

  ttsm_store #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_hit),
    .wr_slot    (wr_slot),
    .wr_data    (cw_data),
    .wr_stamp   (cw_stamp),
    .rd_slot    (rd_slot),
    .rd_data    (st_data),
    .rd_stamp   (st_stamp),
    .rd_written (st_written)
  );

  logic st_fresh;

  ttsm_fresh #(.NSLOT(NSLOT)) u_fresh (
    .now      (gtime),
    .sel_slot (rd_slot),
    .limits   (cfg_acc),
    .stamp    (st_stamp),
    .written  (st_written),
    .fresh    (st_fresh)
  );

  // Output register: next-state and state kept apart.
  logic [DATA_W-1:0] rd_data_d;
  gtime_t            rd_stamp_d;
  logic              rd_valid_d;

  always_comb begin
    rd_data_d  = st_data;
    rd_stamp_d = st_stamp;
    rd_valid_d = st_fresh;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data  <= '0;
      rd_stamp <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_stamp <= rd_stamp_d;
      rd_valid <= rd_valid_d;
    end
  end
endmodule

// File: rtl/ttsm_buffer_chk.sv
module ttsm_buffer_chk
  import ttsm_pkg::*;
#(
  parameter  int NSLOT   = 8,
  parameter  int DATA_W  = 32,
  parameter  int PHASE_W = 4,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [TS_W-1:0]          gtime,
  input logic [NSLOT-1:0]         cfg_slot_en,
  input logic [NSLOT*PHASE_W-1:0] cfg_phase,
  input logic [NSLOT*TS_W-1:0]    cfg_acc,
  input logic [DATA_W-1:0]        cw_data,
  input logic [TS_W-1:0]          cw_stamp,
  input logic [SLOT_W-1:0]        rd_slot,
  input logic [DATA_W-1:0]        rd_data,
  input logic [TS_W-1:0]          rd_stamp,
  input logic                     rd_valid,
  input logic                     wr_hit,
  input logic [SLOT_W-1:0]        wr_slot
);
  gtime_t limit_sel;
  assign limit_sel = cfg_acc[rd_slot*TS_W +: TS_W];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit ##1 (rd_slot == $past(wr_slot)) |=>
      (rd_data == $past(cw_data, 2) && rd_stamp == $past(cw_stamp, 2)));

  p_sched_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> (cfg_phase[wr_slot*PHASE_W +: PHASE_W] == gtime[PHASE_W-1:0]));

  p_read_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_hit) && $stable(rd_slot)) |=> ($stable(rd_data) && $stable(rd_stamp)));

  p_fresh_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!rd_valid || (gtime_t'($past(gtime) - rd_stamp) <= $past(limit_sel))));

  p_disabled_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> cfg_slot_en[wr_slot]);
endmodule

bind ttsm_buffer ttsm_buffer_chk #(
  .NSLOT(NSLOT), .DATA_W(DATA_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .gtime(gtime), .cfg_slot_en(cfg_slot_en),
  .cfg_phase(cfg_phase), .cfg_acc(cfg_acc), .cw_data(cw_data),
  .cw_stamp(cw_stamp), .rd_slot(rd_slot), .rd_data(rd_data),
  .rd_stamp(rd_stamp), .rd_valid(rd_valid), .wr_hit(wr_hit), .wr_slot(wr_slot)
);

// File: tb/ttsm_buffer_tb.sv
`timescale 1ns/1ps
module ttsm_buffer_tb;
  localparam int NSLOT = 8;
  localparam int DW    = 32;
  localparam int PW    = 4;
  localparam int TW    = 32;

  logic              clk;
  logic              rst_n;
  logic [TW-1:0]     gtime;
  logic [NSLOT-1:0]  cfg_slot_en;
  logic [NSLOT*PW-1:0] cfg_phase;
  logic [NSLOT*TW-1:0] cfg_acc;
  logic [DW-1:0]     cw_data;
  logic [TW-1:0]     cw_stamp;
  logic [2:0]        rd_slot;
  logic [DW-1:0]     rd_data;
  logic [TW-1:0]     rd_stamp;
  logic              rd_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ttsm_buffer #(.NSLOT(NSLOT), .DATA_W(DW), .PHASE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .gtime(gtime), .cfg_slot_en(cfg_slot_en),
    .cfg_phase(cfg_phase), .cfg_acc(cfg_acc), .cw_data(cw_data),
    .cw_stamp(cw_stamp), .rd_slot(rd_slot), .rd_data(rd_data),
    .rd_stamp(rd_stamp), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_entry(string req, logic [DW-1:0] d, logic [TW-1:0] s, logic v);
    check(req, 64'(rd_data), 64'(d));
    check(req, 64'(rd_stamp), 64'(s));
    check(req, 64'(rd_valid), 64'(v));
  endtask

  // Scheduled write: gtime hits the phase, then moves to an idle nibble.
  task automatic write_at(logic [TW-1:0] t, logic [DW-1:0] d, logic [TW-1:0] s);
    gtime = t; cw_data = d; cw_stamp = s;
    step();
    gtime = {t[TW-1:4], 4'hF};
  endtask

  task automatic read_at(logic [2:0] slot, logic [TW-1:0] t);
    rd_slot = slot; gtime = t;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; gtime = 32'h0000_000F; rd_slot = 3'd0;
    cw_data = 32'hDEAD_BEEF; cw_stamp = 32'h0;
    for (int i = 0; i < NSLOT; i++) begin
      cfg_phase[i*PW +: PW] = PW'(i);
      cfg_acc[i*TW +: TW]   = (i == 3) ? 32'd10 : 32'd100;
    end
    cfg_slot_en = '1;
    step(); step();
    check_entry("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    step(); step(); step();
    read_at(3'd2, 32'h0000_000F);
    check_entry("R1 after reset", '0, '0, 1'b0);
  endtask

  task automatic t_basic();
    write_at(32'h0000_0102, 32'hA5A5_0002, 32'h0000_0100);
    read_at(3'd2, 32'h0000_010F);
    check_entry("R2 scheduled write", 32'hA5A5_0002, 32'h100, 1'b1);
  endtask

  task automatic t_nonconsume();
    for (int k = 0; k < 3; k++) begin
      read_at(3'd2, 32'h0000_010F);
      check_entry("R4 repeated read", 32'hA5A5_0002, 32'h100, 1'b1);
    end
  endtask

  task automatic t_unsched();
    for (int k = 0; k < 6; k++) begin
      gtime = 32'h0000_0108 + 32'(k);
      cw_data = 32'hBAD0_0000 + 32'(k); cw_stamp = 32'h55;
      step();
    end
    read_at(3'd2, 32'h0000_010F);
    check_entry("R3 unscheduled ignored", 32'hA5A5_0002, 32'h100, 1'b1);
    read_at(3'd6, 32'h0000_010F);
    check_entry("R1 unwritten slot", '0, '0, 1'b0);
  endtask

  task automatic t_overwrite();
    write_at(32'h0000_0112, 32'h2222_0005, 32'h0000_0110);
    read_at(3'd2, 32'h0000_011F);
    check_entry("R2 overwrite in place", 32'h2222_0005, 32'h110, 1'b1);
  endtask

  task automatic t_collision();
    rd_slot = 3'd2; gtime = 32'h0000_0122;
    cw_data = 32'h3333_0006; cw_stamp = 32'h0000_0120;
    step();
    check_entry("R6 same-edge read old", 32'h2222_0005, 32'h110, 1'b1);
    read_at(3'd2, 32'h0000_012F);
    check_entry("R6 next read new", 32'h3333_0006, 32'h120, 1'b1);
  endtask

  task automatic t_latency();
    rd_slot = 3'd0; gtime = 32'h0000_012F;
    #1;
    check("R5 no change before edge", 64'(rd_data), 64'h3333_0006);
    step();
    check_entry("R5 one edge later", '0, '0, 1'b0);
  endtask

  task automatic t_window();
    write_at(32'h0000_0203, 32'h4444_0003, 32'h0000_0200);
    read_at(3'd3, 32'h0000_020A);
    check("R8 age equals limit fresh", 64'(rd_valid), 64'd1);
    read_at(3'd3, 32'h0000_020B);
    check("R8 age limit+1 stale", 64'(rd_valid), 64'd0);
    check("R7 stale keeps data", 64'(rd_data), 64'h4444_0003);
  endtask

  task automatic t_future();
    write_at(32'h0000_0304, 32'h5555_0004, 32'h0000_0400);
    read_at(3'd4, 32'h0000_030F);
    check("R8 future stamp stale", 64'(rd_valid), 64'd0);
    read_at(3'd4, 32'h0000_040F);
    check("R7 stamp reached fresh", 64'(rd_valid), 64'd1);
  endtask

  task automatic t_wrap();
    write_at(32'hFFFF_FFF1, 32'h6666_0001, 32'hFFFF_FFF0);
    read_at(3'd1, 32'h0000_000F);
    check_entry("R8 age across wrap", 32'h6666_0001, 32'hFFFF_FFF0, 1'b1);
  endtask

  task automatic t_priority();
    cfg_phase[6*PW +: PW] = 4'd7;
    write_at(32'h0000_0507, 32'h7777_0006, 32'h0000_0500);
    read_at(3'd6, 32'h0000_050F);
    check_entry("R9 lower slot wins", 32'h7777_0006, 32'h500, 1'b1);
    read_at(3'd7, 32'h0000_050F);
    check_entry("R9 higher slot untouched", '0, '0, 1'b0);
  endtask

  task automatic t_disabled();
    cfg_slot_en[5] = 1'b0;
    write_at(32'h0000_0605, 32'h8888_0005, 32'h0000_0600);
    read_at(3'd5, 32'h0000_060F);
    check_entry("R10 disabled slot", '0, '0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_nonconsume();
    t_unsched();
    t_overwrite();
    t_collision();
    t_latency();
    t_window();
    t_future();
    t_wrap();
    t_priority();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule